// File: doc/BRIEF.md
# Per-Core Task Runqueue Dispatcher

This block is a hardware global scheduler for a cluster of multithreaded cores. It holds one small FIFO of task identifiers per core. All hardware contexts of a core share that FIFO, and the core decides by itself which of its contexts runs the task it receives. New task identifiers arrive on a valid/ready port. Each one is placed in the queue selected by its identifier modulo the number of cores. A core pulls work with a per-core request line. When its queue holds a task, the dispatcher answers in the same cycle with a grant and the head identifier, and it pops that entry at the clock edge.

Each core reports one busy bit per context. The dispatcher reduces these bits to a single flag per core: a core is busy when any of its contexts is busy, and idle otherwise. In static mode, a queued task never leaves its queue. In dynamic mode, a scan pointer visits one core per cycle in ascending order. When the visited core is idle, it can receive the newest task of the lowest-numbered busy core whose queue is not empty. This balancing looks only at the per-core flag and never at how many contexts are busy.

Top module: `core_runq_dispatch`

## Requirements
- R1: While reset is held, every queue is empty, `enq_ready` is high, and no grant is given even with all requests raised.
- R2: An accepted task is appended to queue number `enq_id % NUM_CORES`.
- R3: `grant[c]` equals `req[c]` whenever queue c is non-empty. In that cycle, `grant_id[c*ID_W +: ID_W]` carries the oldest identifier in queue c, and that entry is removed at the clock edge. Each queue delivers its tasks in the order they were appended.
- R4: A request to an empty queue returns no grant, and the request has no effect on any queue.
- R5: `enq_ready` is low exactly when the target queue of `enq_id` holds `QUEUE_DEPTH` tasks. An identifier offered while `enq_ready` is low is dropped.
- R6: A core counts as busy when at least one of its `CTX_PER_CORE` bits in `ctx_busy` is 1; bit `c*CTX_PER_CORE + k` is context k of core c. Any non-zero pattern of those bits has the same effect.
- R7: With `dyn_mode` = 0, no task moves between queues.
- R8: The scan index is 0 in the first cycle after reset and advances by one per cycle, wrapping from NUM_CORES-1 to 0. A migration happens in a cycle when all of the following hold:
  - `dyn_mode` = 1.
  - The core at the scan index is idle and its queue is not full.
  - No enqueue is accepted in that cycle.
  - No migration has yet happened in the current pass.
  - Some busy core has a non-empty queue and no grant in that cycle.

  The migration takes the newest task of the lowest-numbered such busy core and appends it to the scanned core's queue.
- R9: At most one migration happens per scan pass. A pass is the NUM_CORES cycles that start with scan index 0.
- R10: No migration is made into a full queue, even when all other migration conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dyn_mode | input | 1 | 1 = dynamic balancing, 0 = static placement |
| enq_valid | input | 1 | New task offered |
| enq_id | input | ID_W | Identifier of the offered task |
| enq_ready | output | 1 | Target queue can accept the offered task |
| ctx_busy | input | NUM_CORES*CTX_PER_CORE | Per-context busy flags |
| req | input | NUM_CORES | Per-core request for work |
| grant | output | NUM_CORES | Per-core grant, same cycle as the request |
| grant_id | output | NUM_CORES*ID_W | Head identifier per core, valid with grant |

## Verification
Directed sequences target each rule separately:
- Identifiers of distinct residues in static mode show that placement follows the modulo.
- Filling one queue past its depth shows refusal and drop.
- A busy core with a backlog next to idle cores, run in static mode and then in dynamic mode, separates "never moves" from "moves once per pass".
- The same scenario with one busy context and then with two shows that only the reduced flag matters.
- Full idle queues show that migration is suppressed.

A long random phase mixes enqueues, requests, context activity and mode changes. It is compared against a cycle-level model in the bench, which catches conflicts among enqueue, dispatch and migration in the same cycle.

// File: rtl/rqd_pkg.sv
package rqd_pkg;

  typedef enum logic {
    BAL_STATIC  = 1'b0,
    BAL_DYNAMIC = 1'b1
  } bal_mode_e;

endpackage

// File: rtl/rqd_fifo.sv
module rqd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_head,
  input  logic         drop_tail,
  output logic [W-1:0] head,
  output logic [W-1:0] tail,
  output logic         full,
  output logic         empty
);

  // DEPTH must be a power of two so the pointers wrap naturally
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [PW-1:0] wr_ptr, tl_ptr;

  assign wr_ptr = rd_ptr + PW'(cnt);
  assign tl_ptr = rd_ptr + PW'(cnt) - PW'(1);
  assign head   = mem[rd_ptr];
  assign tail   = mem[tl_ptr];
  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);

  always_comb begin
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (pop_head) rd_ptr_nxt = rd_ptr + PW'(1);
    case ({push, pop_head, drop_tail})
      3'b100:  cnt_nxt = cnt + CW'(1);
      3'b010,
      3'b001:  cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_head || drop_tail) |-> (cnt != '0));

  p_one_removal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_head && drop_tail) && !(push && drop_tail));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt + CW'(1) == $past(cnt)));

endmodule

// File: rtl/rqd_balancer.sv
module rqd_balancer #(
  parameter int NUM_CORES = 4,
  parameter int CI        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rqd_pkg::bal_mode_e   mode,
  input  logic [NUM_CORES-1:0] core_busy,
  input  logic [NUM_CORES-1:0] q_empty,
  input  logic [NUM_CORES-1:0] q_full,
  input  logic [NUM_CORES-1:0] q_pop,
  input  logic                 enq_fire,
  output logic                 mig_fire,
  output logic [CI-1:0]        mig_src,
  output logic [CI-1:0]        mig_dst
);

  logic [CI-1:0] scan_idx, scan_nxt;
  logic          moved, moved_nxt;
  logic          src_found;
  logic          last_step;

  // lowest-numbered busy core with a queued task not being dispatched
  always_comb begin
    src_found = 1'b0;
    mig_src   = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (core_busy[c] && !q_empty[c] && !q_pop[c]) begin
        src_found = 1'b1;
        mig_src   = CI'(c);
      end
    end
  end

  assign mig_dst   = scan_idx;
  assign last_step = (scan_idx == CI'(NUM_CORES - 1));
  assign mig_fire  = (mode == rqd_pkg::BAL_DYNAMIC) && !moved && src_found &&
                     !core_busy[scan_idx] && !q_full[scan_idx] && !enq_fire;

  always_comb begin
    scan_nxt  = last_step ? '0 : scan_idx + CI'(1);
    moved_nxt = last_step ? 1'b0 : (moved || mig_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_idx <= '0;
      moved    <= 1'b0;
    end else begin
      scan_idx <= scan_nxt;
      moved    <= moved_nxt;
    end
  end

  // checker-side count of migrations within the current pass
  logic [1:0] pass_migs;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pass_migs <= '0;
    else if (scan_nxt == '0)          pass_migs <= '0;
    else if (mig_fire && pass_migs != 2'd3) pass_migs <= pass_migs + 2'd1;
  end

  p_one_per_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_migs != 2'd0) |-> !mig_fire);

  p_mig_direction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mig_fire |-> (core_busy[mig_src] && !core_busy[mig_dst] && !q_empty[mig_src]));

  p_mig_not_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mig_fire |-> !q_full[mig_dst]);

endmodule

// File: rtl/core_runq_dispatch.sv
module core_runq_dispatch #(
  parameter int NUM_CORES    = 4,
  parameter int CTX_PER_CORE = 2,
  parameter int QUEUE_DEPTH  = 4,
  parameter int ID_W         = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dyn_mode,
  input  logic                              enq_valid,
  input  logic [ID_W-1:0]                   enq_id,
  output logic                              enq_ready,
  input  logic [NUM_CORES*CTX_PER_CORE-1:0] ctx_busy,
  input  logic [NUM_CORES-1:0]              req,
  output logic [NUM_CORES-1:0]              grant,
  output logic [NUM_CORES*ID_W-1:0]         grant_id
);

  localparam int CI = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  rqd_pkg::bal_mode_e   mode;
  logic [NUM_CORES-1:0] core_busy, q_empty, q_full;
  logic [ID_W-1:0]      q_head [NUM_CORES];
  logic [ID_W-1:0]      q_tail [NUM_CORES];
  logic [CI-1:0]        tgt, mig_src, mig_dst;
  logic                 enq_fire, mig_fire;
  logic [ID_W-1:0]      mig_data;

  assign mode      = dyn_mode ? rqd_pkg::BAL_DYNAMIC : rqd_pkg::BAL_STATIC;
  assign tgt       = CI'(enq_id % ID_W'(NUM_CORES));
  assign enq_ready = !q_full[tgt];
  assign enq_fire  = enq_valid && enq_ready;
  assign grant     = req & ~q_empty;
  assign mig_data  = q_tail[mig_src];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic push_c;

    assign core_busy[c] = |ctx_busy[c*CTX_PER_CORE +: CTX_PER_CORE];
    assign push_c = (enq_fire && tgt == CI'(c)) || (mig_fire && mig_dst == CI'(c));
    assign grant_id[c*ID_W +: ID_W] = q_head[c];

    rqd_fifo #(.DEPTH(QUEUE_DEPTH), .W(ID_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_c),
      .push_data (enq_fire ? enq_id : mig_data),
      .pop_head  (grant[c]),
      .drop_tail (mig_fire && mig_src == CI'(c)),
      .head      (q_head[c]),
      .tail      (q_tail[c]),
      .full      (q_full[c]),
      .empty     (q_empty[c])
    );
  end

  rqd_balancer #(.NUM_CORES(NUM_CORES), .CI(CI)) u_bal (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .core_busy (core_busy),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .q_pop     (grant),
    .enq_fire  (enq_fire),
    .mig_fire  (mig_fire),
    .mig_src   (mig_src),
    .mig_dst   (mig_dst)
  );

  p_static_no_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_mode |-> !mig_fire);

  p_enq_excl_mig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready) |-> !mig_fire);

endmodule

// File: tb/core_runq_dispatch_tb.sv
module core_runq_dispatch_tb;

  localparam int NC = 4;
  localparam int NX = 2;
  localparam int DP = 4;
  localparam int IW = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dyn_mode;
  logic              enq_valid;
  logic [IW-1:0]     enq_id;
  logic              enq_ready;
  logic [NC*NX-1:0]  ctx_busy;
  logic [NC-1:0]     req;
  logic [NC-1:0]     grant;
  logic [NC*IW-1:0]  grant_id;

  always #10 clk = ~clk;

  core_runq_dispatch #(.NUM_CORES(NC), .CTX_PER_CORE(NX), .QUEUE_DEPTH(DP), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .enq_valid(enq_valid), .enq_id(enq_id),
    .enq_ready(enq_ready), .ctx_busy(ctx_busy), .req(req), .grant(grant), .grant_id(grant_id)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [IW-1:0] mq [NC][DP];
  int            mc [NC];
  int            m_scan;
  bit            m_moved;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int c = 0; c < NC; c++) mc[c] = 0;
    m_scan  = 0;
    m_moved = 1'b0;
  endfunction

  // one clock cycle: drive just after a negedge, check, update model, wait next negedge
  task automatic cyc(input bit dyn, input bit ev, input logic [IW-1:0] id,
                     input logic [NC-1:0] rq, input logic [NC*NX-1:0] ctx, input string tag);
    int tgt, src;
    bit fire, mig;
    bit g [NC];
    bit act [NC];
    logic [IW-1:0] tv;
    dyn_mode = dyn; enq_valid = ev; enq_id = id; req = rq; ctx_busy = ctx;
    #2;
    tgt  = int'(id) % NC;
    fire = ev && (mc[tgt] < DP);
    chk(enq_ready == (mc[tgt] < DP), "R5", "enq_ready", int'(enq_ready), int'(mc[tgt] < DP));
    for (int c = 0; c < NC; c++) begin
      g[c] = rq[c] && (mc[c] > 0);
      chk(grant[c] == g[c], (rq[c] && mc[c] == 0) ? "R4" : "R3", "grant", int'(grant[c]), int'(g[c]));
      if (g[c])
        chk(grant_id[c*IW +: IW] == mq[c][0], tag, "grant_id", int'(grant_id[c*IW +: IW]), int'(mq[c][0]));
      act[c] = |ctx[c*NX +: NX];
    end
    src = -1;
    for (int c = NC - 1; c >= 0; c--)
      if (act[c] && mc[c] > 0 && !g[c]) src = c;
    mig = dyn && !m_moved && !act[m_scan] && (mc[m_scan] < DP) && (src >= 0) && !fire;
    tv = '0;
    if (mig) begin
      tv = mq[src][mc[src]-1];
      mc[src]--;
    end
    for (int c = 0; c < NC; c++) begin
      if (g[c]) begin
        for (int k = 0; k < DP - 1; k++) mq[c][k] = mq[c][k+1];
        mc[c]--;
      end
    end
    if (mig) begin
      mq[m_scan][mc[m_scan]] = tv;
      mc[m_scan]++;
    end
    if (fire) begin
      mq[tgt][mc[tgt]] = id;
      mc[tgt]++;
    end
    if (m_scan == NC - 1) begin
      m_scan  = 0;
      m_moved = 1'b0;
    end else begin
      m_scan++;
      m_moved = m_moved || mig;
    end
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 2 * DP + 2; i++) cyc(1'b0, 1'b0, '0, '1, '0, tag);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; dyn_mode = 1'b0; enq_valid = 1'b0; enq_id = '0; req = '0; ctx_busy = '0;
    repeat (3) @(negedge clk);
    req = '1; enq_id = 8'd3;
    #2;
    chk(enq_ready == 1'b1, "R1", "enq_ready in reset", int'(enq_ready), 1);
    chk(grant == '0, "R1", "grant in reset", int'(grant), 0);
    rst_n = 1'b1;
    model_reset();

    // R2: static placement by modulo, then FIFO dispatch
    cyc(1'b0, 1'b1, 8'd6, '0, '0, "R2");
    cyc(1'b0, 1'b1, 8'd1, '0, '0, "R2");
    cyc(1'b0, 1'b1, 8'd4, '0, '0, "R2");
    cyc(1'b0, 1'b1, 8'd3, '0, '0, "R2");
    cyc(1'b0, 1'b1, 8'd9, '0, '0, "R2");
    cyc(1'b0, 1'b1, 8'd14, '0, '0, "R2");
    drain("R3");

    // R5: overfill queue 2
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, IW'(2 + 4 * i), '0, '0, "R5");
    drain("R5");

    // R7: static mode never moves a backlog to idle cores
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, IW'(4 * i), '0, 8'b0000_0001, "R7");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, '0, 4'b1110, 8'b0000_0001, "R7");
    drain("R7");

    // R8/R9: dynamic balancing, core 0 busy through one context
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, IW'(4 * i), '0, 8'b0000_0010, "R8");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, '0, '0, 8'b0000_0010, "R9");
    cyc(1'b1, 1'b0, '0, 4'b1110, 8'b0000_0010, "R9");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, '0, '0, 8'b0000_0010, "R8");
    drain("R8");

    // R6: same scenario, both contexts of core 0 busy
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, IW'(8 + 4 * i), '0, 8'b0000_0011, "R6");
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, '0, '0, 8'b0000_0011, "R6");
    drain("R6");

    // R10: idle queues full, no migration into them
    for (int q = 1; q < NC; q++)
      for (int i = 0; i < DP; i++) cyc(1'b0, 1'b1, IW'(q + 4 * i), '0, '0, "R10");
    cyc(1'b0, 1'b1, 8'd0, '0, '0, "R10");
    cyc(1'b0, 1'b1, 8'd4, '0, '0, "R10");
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, '0, '0, 8'b0000_0001, "R10");
    drain("R10");

    // random traffic with mode changes
    for (int i = 0; i < 4000; i++) begin
      logic [NC*NX-1:0] cx;
      logic [NC-1:0]    rq;
      cx = '0;
      for (int b = 0; b < NC * NX; b++) cx[b] = ($urandom % 4) == 0;
      for (int b = 0; b < NC; b++) rq[b] = ($urandom % 3) == 0;
      cyc(((i / 500) % 2) == 1, ($urandom % 2) == 1, IW'($urandom), rq, cx, "R8");
    end
    drain("R3");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule